// File: doc/BRIEF.md
# Floating-Point Product Exception and Status Unit

This combinational block closes out a single-precision multiplier. The block receives five things. The first is the two original operands. The second is the sign of the product. The third is the exponent as it leaves the pipeline register, in biased two's complement form, after the product has been normalized. The fourth is the 25-bit mantissa that the rounding stage produced, together with the active rounding mode. The fifth is the inexact indication from rounding. From these it forms the final 32-bit result word and an 8-bit status vector.

Each operand is classified from its own bit pattern as zero, infinity, NaN or finite non-zero. Special operands take priority over the datapath result. The datapath result is renormalized when rounding carried into bit 24. It is then checked against the exponent range. Results that fall off the top are saturated as the rounding mode directs. Results that fall off the bottom are flushed to zero, or bumped to the smallest normal value, and are never emitted as denormals.

Top module: `fpx_status_unit`

## Requirements
- R1: The status vector uses these positions: bit 0 means the result is ±0, bit 1 means ±infinity, bit 2 means a NaN result, bit 3 means underflow, bit 4 means overflow and bit 5 means inexact. Bits 6 and 7 always read 0.
- R2: A NaN operand is an exponent field of all ones with a non-zero fraction. When either operand is NaN, the result is 0x7FC00000 and the status is only bit 2.
- R3: A zero operand multiplied by an infinite one, in either order, gives 0x7FC00000 with status only bit 2.
- R4: When one operand is infinite and the other is finite and non-zero, or both are infinite, the result is infinity carrying `prod_sign` and the status is only bit 1.
- R5: When one operand is ±0 and the other is finite, the result is zero carrying `prod_sign` and the status is only bit 0. The mantissa, exponent and inexact inputs have no effect in this case.
- R6: When `rnd_mant[24]` is 1, the fraction comes from `rnd_mant[23:1]` and the exponent is `prod_exp`+1. Otherwise the fraction comes from `rnd_mant[22:0]` and the exponent is `prod_exp`.
- R7: An adjusted exponent of 255 or more is an overflow. The status has bits 4 and 5 set. The mode codes are: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf, 4 nearest-away, 5 away from zero, and 6 and 7 act as 0. The result is signed infinity with bit 1 set in modes 0, 4 and 5, in mode 2 for a positive product and in mode 3 for a negative one. Otherwise it is the largest finite value of that sign (exponent 254, fraction all ones).
- R8: An adjusted exponent of 0 or less is an underflow. The status has bits 3 and 5 set. The result is the smallest normal value of that sign (exponent 1, fraction 0) in mode 5, in mode 2 for a positive product and in mode 3 for a negative one. Otherwise it is signed zero with bit 0 also set.
- R9: An in-range adjusted exponent (1 to 254) gives the word {sign, exponent, fraction}. Its only possible status bit is bit 5, which copies `inexact_in`.
- R10: Status bits 0 and 1 are never both set, and at most one of bits 0, 1 and 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First original operand |
| op_b | input | 32 | Second original operand |
| rnd_mant | input | 25 | Rounded mantissa including the hidden bit and the carry bit |
| prod_exp | input | 10 | Biased exponent of the product, two's complement |
| prod_sign | input | 1 | Sign of the product |
| rnd_mode | input | 3 | Rounding mode code |
| inexact_in | input | 1 | Rounding discarded non-zero bits |
| result | output | 32 | Final product word |
| status | output | 8 | Exception and status flags |

## Verification
Two functions of this block can act on the same input set. The first is the rounding-carry renormalization and the second is the range check. One pairing is the exponent 254 with `rnd_mant[24]` set, where the carry pushes the result into overflow. The other is the exponent 0 with the carry set, where the carry lifts the result out of underflow. The special-operand rules also meet datapath inputs that would saturate on their own. Zero and infinity operands are applied with overflowing exponents and with the inexact flag set. Each case is judged against a behavioural model evaluated on every clock, which has to predict that the carry decides the range outcome and that special operands mask saturation entirely.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  // rounding mode codes
  localparam logic [2:0] RM_NEAR_EVEN = 3'd0;
  localparam logic [2:0] RM_TO_ZERO   = 3'd1;
  localparam logic [2:0] RM_UP        = 3'd2;
  localparam logic [2:0] RM_DOWN      = 3'd3;
  localparam logic [2:0] RM_NEAR_AWAY = 3'd4;
  localparam logic [2:0] RM_AWAY      = 3'd5;

  // status vector bit positions
  localparam int FLG_ZERO    = 0;
  localparam int FLG_INF     = 1;
  localparam int FLG_NAN     = 2;
  localparam int FLG_TINY    = 3;
  localparam int FLG_HUGE    = 4;
  localparam int FLG_INEXACT = 5;
  localparam int FLG_W       = 8;

  typedef struct packed {
    logic is_zero;
    logic is_inf;
    logic is_nan;
  } opclass_t;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op,
  output opclass_t             cls
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             exp_max;

  assign exp_f   = op[EXP_W+MAN_W-1:MAN_W];
  assign frac_f  = op[MAN_W-1:0];
  assign exp_max = &exp_f;

  always_comb begin
    cls.is_zero = (exp_f == '0) && (frac_f == '0);
    cls.is_inf  = exp_max && (frac_f == '0);
    cls.is_nan  = exp_max && (frac_f != '0);
  end
endmodule

// File: rtl/fpx_renorm.sv
module fpx_renorm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [MAN_W+1:0]        mant_in,
  input  logic signed [EXP_W+1:0] exp_in,
  output logic [MAN_W-1:0]        frac,
  output logic signed [EXP_W+2:0] exp_adj
);
  logic carry;

  assign carry = mant_in[MAN_W+1];

  always_comb begin
    if (carry) frac = mant_in[MAN_W:1];
    else       frac = mant_in[MAN_W-1:0];
    exp_adj = $signed({exp_in[EXP_W+1], exp_in})
            + $signed({{(EXP_W+2){1'b0}}, carry});
  end
endmodule

// File: rtl/fpx_saturate.sv
module fpx_saturate
  import fpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic               sign,
  input  logic [2:0]         mode,
  input  logic               ovf,
  input  logic               udf,
  output logic [EXP_W+MAN_W:0] sat_word,
  output logic               sat_is_inf,
  output logic               sat_is_zero
);
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_BIG  = EXP_ONES - 1'b1;
  localparam logic [EXP_W-1:0] EXP_ONE  = {{(EXP_W-1){1'b0}}, 1'b1};

  logic grow;
  logic bump;

  always_comb begin
    unique case (mode)
      RM_TO_ZERO: grow = 1'b0;
      RM_UP:      grow = !sign;
      RM_DOWN:    grow = sign;
      default:    grow = 1'b1;
    endcase
    bump = (mode == RM_AWAY) || ((mode == RM_UP) && !sign)
        || ((mode == RM_DOWN) && sign);
  end

  always_comb begin
    sat_word    = '0;
    sat_is_inf  = 1'b0;
    sat_is_zero = 1'b0;
    if (ovf) begin
      sat_is_inf = grow;
      sat_word   = grow ? {sign, EXP_ONES, {MAN_W{1'b0}}}
                        : {sign, EXP_BIG, {MAN_W{1'b1}}};
    end else if (udf) begin
      sat_is_zero = !bump;
      sat_word    = bump ? {sign, EXP_ONE, {MAN_W{1'b0}}}
                         : {sign, {(EXP_W+MAN_W){1'b0}}};
    end
  end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]  op_a,
  input  logic [EXP_W+MAN_W:0]  op_b,
  input  logic [MAN_W+1:0]      rnd_mant,
  input  logic [EXP_W+1:0]      prod_exp,
  input  logic                  prod_sign,
  input  logic [2:0]            rnd_mode,
  input  logic                  inexact_in,
  output logic [EXP_W+MAN_W:0]  result,
  output logic [FLG_W-1:0]      status
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic signed [EXP_W+2:0] EXP_LIMIT =
    $signed({3'b000, {EXP_W{1'b1}}});
  localparam logic [W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] MIN_NORM_MAG =
    {1'b0, {(EXP_W-1){1'b0}}, 1'b1, {MAN_W{1'b0}}};

  logic [W-1:0] ops [2];
  opclass_t     cls [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpx_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (ops[g]),
      .cls (cls[g])
    );
  end

  logic any_nan, invalid, any_inf, any_zero;
  assign any_nan  = cls[0].is_nan | cls[1].is_nan;
  assign invalid  = (cls[0].is_zero & cls[1].is_inf) | (cls[0].is_inf & cls[1].is_zero);
  assign any_inf  = cls[0].is_inf | cls[1].is_inf;
  assign any_zero = cls[0].is_zero | cls[1].is_zero;

  logic [MAN_W-1:0]        frac;
  logic signed [EXP_W+2:0] exp_adj;

  fpx_renorm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_renorm (
    .mant_in (rnd_mant),
    .exp_in  ($signed(prod_exp)),
    .frac    (frac),
    .exp_adj (exp_adj)
  );

  logic ovf, udf;
  assign ovf = (exp_adj >= EXP_LIMIT);
  assign udf = (exp_adj <= $signed({(EXP_W+3){1'b0}}));

  logic [W-1:0] sat_word;
  logic         sat_is_inf, sat_is_zero;

  fpx_saturate #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sat (
    .sign        (prod_sign),
    .mode        (rnd_mode),
    .ovf         (ovf),
    .udf         (udf),
    .sat_word    (sat_word),
    .sat_is_inf  (sat_is_inf),
    .sat_is_zero (sat_is_zero)
  );

  always_comb begin
    result = '0;
    status = '0;
    if (any_nan || invalid) begin
      result          = QNAN;
      status[FLG_NAN] = 1'b1;
    end else if (any_inf) begin
      result          = {prod_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      status[FLG_INF] = 1'b1;
    end else if (any_zero) begin
      result           = {prod_sign, {(W-1){1'b0}}};
      status[FLG_ZERO] = 1'b1;
    end else if (ovf) begin
      result              = sat_word;
      status[FLG_HUGE]    = 1'b1;
      status[FLG_INEXACT] = 1'b1;
      status[FLG_INF]     = sat_is_inf;
    end else if (udf) begin
      result              = sat_word;
      status[FLG_TINY]    = 1'b1;
      status[FLG_INEXACT] = 1'b1;
      status[FLG_ZERO]    = sat_is_zero;
    end else begin
      result              = {prod_sign, exp_adj[EXP_W-1:0], frac};
      status[FLG_INEXACT] = inexact_in;
    end
  end

  // checks beside the output logic
  always_comb begin
    p_zero_inf_excl_r10: assert ($isunknown(status) ||
      ($countones(status[FLG_NAN:FLG_ZERO]) <= 1))
      else $error("zero/inf/nan flags overlap");
    p_nan_canon_r2: assert ($isunknown({op_a, op_b, result}) ||
      !any_nan || (result == QNAN))
      else $error("NaN operand did not give canonical NaN");
    p_zero_mag_r5: assert ($isunknown({status, result}) ||
      !status[FLG_ZERO] || (result[W-2:0] == '0))
      else $error("zero flag with non-zero magnitude");
    p_huge_exp_r7: assert ($isunknown({status, result}) ||
      !status[FLG_HUGE] || (result[W-2:MAN_W] >= {{(EXP_W-1){1'b1}}, 1'b0}))
      else $error("overflow result below largest exponent");
    p_tiny_mag_r8: assert ($isunknown({status, result}) ||
      !status[FLG_TINY] || (result[W-2:0] == '0) ||
      (result[W-2:0] == MIN_NORM_MAG[W-2:0]))
      else $error("underflow result is neither zero nor min normal");
  end
endmodule

// File: tb/tb_fpx_status_unit.sv
`timescale 1ns/1ps
module tb_fpx_status_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] op_a, op_b;
  logic [24:0] rnd_mant;
  logic [9:0]  prod_exp;
  logic        prod_sign;
  logic [2:0]  rnd_mode;
  logic        inexact_in;
  logic [31:0] result;
  logic [7:0]  status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  fpx_status_unit dut (
    .op_a(op_a), .op_b(op_b), .rnd_mant(rnd_mant), .prod_exp(prod_exp),
    .prod_sign(prod_sign), .rnd_mode(rnd_mode), .inexact_in(inexact_in),
    .result(result), .status(status)
  );

  // behavioural reference
  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       input logic [24:0] m, input int e, input logic s,
                       input int md, input logic inx,
                       output logic [31:0] r, output logic [7:0] st,
                       output string tag);
    bit an, bn, ai, bi, az, bz, up;
    int ee;
    logic [22:0] fr;
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    az = (a[30:0] == 0);
    bz = (b[30:0] == 0);
    if (an || bn) begin r = 32'h7FC00000; st = 8'h04; tag = "R2"; end
    else if ((az && bi) || (ai && bz)) begin r = 32'h7FC00000; st = 8'h04; tag = "R3"; end
    else if (ai || bi) begin r = {s, 8'hFF, 23'd0}; st = 8'h02; tag = "R4"; end
    else if (az || bz) begin r = {s, 31'd0}; st = 8'h01; tag = "R5"; end
    else begin
      ee = e;
      if (m[24]) begin ee = e + 1; fr = m[23:1]; end
      else fr = m[22:0];
      if (ee >= 255) begin
        if (md == 1) up = 0;
        else if (md == 2) up = !s;
        else if (md == 3) up = s;
        else up = 1;
        r  = up ? {s, 8'hFF, 23'd0} : {s, 8'hFE, {23{1'b1}}};
        st = up ? 8'h32 : 8'h30;
        tag = "R7";
      end else if (ee <= 0) begin
        up = (md == 5) || (md == 2 && !s) || (md == 3 && s);
        r  = up ? {s, 8'h01, 23'd0} : {s, 31'd0};
        st = up ? 8'h28 : 8'h29;
        tag = "R8";
      end else begin
        r  = {s, ee[7:0], fr};
        st = inx ? 8'h20 : 8'h00;
        tag = "R9";
      end
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [24:0] m, input int e, input int md,
                       input logic inx, input string note);
    logic [31:0] er;
    logic [7:0]  es;
    string tag;
    logic s;
    s = a[31] ^ b[31];
    @(posedge clk);
    #1;
    op_a = a; op_b = b; rnd_mant = m; prod_exp = 10'(e);
    prod_sign = s; rnd_mode = 3'(md); inexact_in = inx;
    model(a, b, m, e, s, md, inx, er, es, tag);
    @(negedge clk);
    checks++;
    if (result !== er || status !== es) begin
      failures++;
      $display("FAIL %s %s: result=%h status=%h expected result=%h status=%h",
               tag, note, result, status, er, es);
    end
    checks++;
    if (status[7:6] !== 2'b00) begin // R1 reserved bits
      failures++;
      $display("FAIL R1 %s: status[7:6]=%b expected 00", note, status[7:6]);
    end
  endtask

  function automatic logic [31:0] rand_op(input int kind);
    logic [31:0] v;
    v = $urandom;
    case (kind)
      0: v = {v[31], 31'd0};
      1: v = {v[31], 8'hFF, 23'd0};
      2: v = {v[31], 8'hFF, v[22:0] | 23'd1};
      3: v = {v[31], 8'h00, v[22:0] | 23'd1};
      default: if (v[30:23] == 8'hFF || v[30:23] == 8'h00) v[30:23] = 8'h80;
    endcase
    return v;
  endfunction

  localparam logic [31:0] ONE  = 32'h3F800000;
  localparam logic [31:0] NONE = 32'hBF800000;

  initial begin
    // R5 reset-like state: all inputs zero
    apply(32'd0, 32'd0, 25'd0, 0, 0, 1'b0, "all-zero inputs R5");
    apply(32'h7FC00001, ONE, 25'h0ABCDE, 100, 0, 1'b1, "qnan x one R2");
    apply(32'hFF800000, 32'hFF800001, 25'h0, 100, 2, 1'b0, "inf x snan R2");
    apply(32'h00000000, 32'h7F800000, 25'h1FFFFFF, 300, 0, 1'b1, "zero x inf R3");
    apply(32'hFF800000, 32'h80000000, 25'h0, -50, 3, 1'b0, "inf x zero R3");
    apply(32'h7F800000, NONE, 25'h0, -100, 1, 1'b1, "inf x neg R4");
    apply(32'h7F800000, 32'hFF800000, 25'h0, 400, 0, 1'b0, "inf x inf R4");
    apply(32'h80000000, ONE, 25'h1FFFFFF, 400, 2, 1'b1, "zero masks overflow R5");
    apply(NONE, 32'h00000000, 25'h0800001, -10, 5, 1'b1, "zero masks underflow R5");
    apply(ONE, ONE, 25'h1800003, 100, 0, 1'b0, "carry renorm R6");
    apply(ONE, ONE, 25'h0C00003, 100, 0, 1'b1, "no carry R6 R9");
    apply(ONE, ONE, 25'h1000000, 254, 0, 1'b0, "carry into overflow R6 R7");
    apply(ONE, ONE, 25'h0FFFFFF, 254, 1, 1'b1, "top exponent R9");
    apply(ONE, ONE, 25'h1000000, 0, 0, 1'b0, "carry out of underflow R6");
    apply(ONE, ONE, 25'h0800000, 1, 0, 1'b0, "min exponent R9");
    for (int md = 0; md < 8; md++) begin
      apply(ONE, ONE, 25'h0800000, 300, md, 1'b0, "overflow pos R7");
      apply(NONE, ONE, 25'h0800000, 255, md, 1'b0, "overflow neg R7");
      apply(ONE, ONE, 25'h0800000, 0, md, 1'b0, "underflow pos R8");
      apply(ONE, NONE, 25'h0800000, -200, md, 1'b1, "underflow neg R8");
    end
    for (int i = 0; i < 600; i++) begin
      int ka, kb;
      ka = ($urandom_range(9) < 6) ? 4 : $urandom_range(3);
      kb = ($urandom_range(9) < 6) ? 4 : $urandom_range(3);
      apply(rand_op(ka), rand_op(kb), 25'($urandom) | 25'h0800000,
            int'($urandom_range(600)) - 200, $urandom_range(7),
            1'($urandom), "random R10");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule